// File: doc/BRIEF.md
# Selectable Serial Line Encoder/Decoder

This block sits between a bit-serial data path and a physical line. On the transmit side it accepts one data bit per bit cell and drives a line level that can change at the start of the cell and again at its middle, so the line runs at twice the bit rate. On the receive side it takes the line level at two sample points per cell, one in the first half and one in the second half, and returns one decoded bit per cell. The sample points come from an external recovered-clock enable. Clock recovery and character framing belong to neighbouring blocks.

The line code is chosen at run time through a three-bit mode input. One shared datapath serves all five codes: plain level (NRZ), level-change-on-zero (NRZI), two biphase-space/mark variants (FM0, FM1) and split-phase (Manchester). A new mode is only adopted at a bit boundary. When the mode changes, the differential reference restarts from the high level on both sides, so a transmitter and receiver that switch together stay aligned. Bits go out in the order they are presented, which lets an upstream serializer place the least significant bit first. The receiver also flags cells that break the rules of the active code.

Top module: `line_codec`

## Requirements
- R1: While reset is asserted and on release, line_out is high and rx_valid, rx_bit and rx_err are low.
- R2: When tx_en is low, line_out is high (mark) from the next clock on, tx_req stays low, and the next enabled tx_tick starts a new bit cell.
- R3: Mode code 0 (NRZ) drives the data bit in both halves of the cell.
- R4: Mode code 1 (NRZI) inverts the previous line level for a 0 and keeps it for a 1, holding that level for the whole cell.
- R5: Mode code 2 (FM0) inverts the line at the start of every cell and inverts it again at mid-cell only for a 0.
- R6: Mode code 3 (FM1) inverts the line at the start of every cell and inverts it again at mid-cell only for a 1.
- R7: Mode code 4 (Manchester) drives high then low for a 1 and low then high for a 0.
- R8: One clock after a second-half receive sample, rx_valid is high for exactly one cycle, and rx_bit holds the bit that the active mode decodes from the two samples of the cell. A transmitter looped back to the receiver recovers the transmitted data in every mode.
- R9: A mode change that arrives in the middle of a cell does not affect that cell. The new mode applies from the next cell, and the previous-level reference restarts at high in both directions.
- R10: rx_err is high together with rx_valid when a cell violates the code: in Manchester, both samples are equal; in FM0 or FM1, the first-half sample equals the level that ended the previous cell. It is low otherwise.
- R11: Mode codes 5, 6 and 7 behave exactly like NRZ.
- R12: tx_req is high, combinationally, in the cycle where tx_tick opens a new cell while tx_en is high. In that cycle tx_data is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Line code select (0 NRZ, 1 NRZI, 2 FM0, 3 FM1, 4 Manchester, others NRZ) |
| tx_en | input | 1 | Transmitter enable; low holds the line at mark |
| tx_tick | input | 1 | Half-cell enable for the transmitter |
| tx_data | input | 1 | Data bit, taken when tx_req is high |
| tx_req | output | 1 | Marks the cycle in which tx_data is consumed |
| line_out | output | 1 | Encoded line level |
| rx_tick | input | 1 | Receive sample enable from clock recovery |
| rx_half | input | 1 | 0 for the first-half sample, 1 for the second-half sample |
| rx_line | input | 1 | Received line level |
| rx_bit | output | 1 | Last decoded bit |
| rx_valid | output | 1 | One-cycle pulse when rx_bit is updated |
| rx_err | output | 1 | Code violation for the cell just decoded |

## Verification
Each code gets several bit sequences. Runs of equal bits separate the differential codes from the level codes, because NRZI and FM only show their behaviour through the level carried over from the previous cell. Alternating patterns separate FM0 from FM1, and they separate both from Manchester, whose first half follows the data instead of toggling. A mode switch inside a cell shows whether the switch waits for the boundary and restarts the reference. Forced line levels on the receiver show that the violation flag fires only on illegal cells.

// File: rtl/line_codec_pkg.sv
package line_codec_pkg;

  localparam int LC_MODE_W = 3;

  typedef enum logic [LC_MODE_W-1:0] {
    LC_NRZ   = 3'd0,
    LC_NRZI  = 3'd1,
    LC_FM0   = 3'd2,
    LC_FM1   = 3'd3,
    LC_MANCH = 3'd4
  } lc_mode_e;

  // Unassigned codes fall back to plain level coding.
  function automatic lc_mode_e lc_map_mode(input logic [LC_MODE_W-1:0] raw);
    lc_mode_e m;
    case (raw)
      3'd1:    m = LC_NRZI;
      3'd2:    m = LC_FM0;
      3'd3:    m = LC_FM1;
      3'd4:    m = LC_MANCH;
      default: m = LC_NRZ;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/lc_mode_track.sv
module lc_mode_track
  import line_codec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  lc_mode_e mode_in,
  output lc_mode_e mode_cur,
  output logic     mode_diff
);

  lc_mode_e mode_q, mode_d;

  assign mode_diff = (mode_in != mode_q);
  assign mode_cur  = mode_q;

  always_comb begin
    mode_d = mode_q;
    if (load) mode_d = mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LC_NRZ;
    else        mode_q <= mode_d;
  end

endmodule

// File: rtl/lc_encoder.sv
module lc_encoder
  import line_codec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick,
  input  logic     data,
  input  lc_mode_e mode_in,
  output logic     line,
  output logic     req
);

  logic     phase_q, phase_d;
  logic     line_q, line_d;
  logic     bit_q, bit_d;
  logic     boundary, midcell, base;
  lc_mode_e cur_mode;
  logic     mode_diff;

  assign boundary = en & tick & ~phase_q;
  assign midcell  = en & tick & phase_q;
  assign base     = mode_diff ? 1'b1 : line_q;
  assign req      = boundary;
  assign line     = line_q;

  lc_mode_track u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (boundary),
    .mode_in  (mode_in),
    .mode_cur (cur_mode),
    .mode_diff(mode_diff)
  );

  always_comb begin
    phase_d = phase_q;
    line_d  = line_q;
    bit_d   = bit_q;
    if (!en) begin
      line_d  = 1'b1;
      phase_d = 1'b0;
    end else if (boundary) begin
      phase_d = 1'b1;
      bit_d   = data;
      case (mode_in)
        LC_NRZI:        line_d = data ? base : ~base;
        LC_FM0, LC_FM1: line_d = ~base;
        default:        line_d = data;
      endcase
    end else if (midcell) begin
      phase_d = 1'b0;
      case (cur_mode)
        LC_FM0:   line_d = bit_q ? line_q : ~line_q;
        LC_FM1:   line_d = bit_q ? ~line_q : line_q;
        LC_MANCH: line_d = ~bit_q;
        default:  line_d = line_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      line_q  <= 1'b1;
      bit_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      line_q  <= line_d;
      bit_q   <= bit_d;
    end
  end

endmodule

// File: rtl/lc_decoder.sv
module lc_decoder
  import line_codec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     half,
  input  logic     line,
  input  lc_mode_e mode_in,
  output logic     bit_out,
  output logic     valid,
  output logic     err
);

  logic     first_s, second_s;
  logic     h1_q, h1_d;
  logic     ref_q, ref_d;
  logic     bit_q, bit_d;
  logic     valid_q, valid_d;
  logic     err_q, err_d;
  lc_mode_e cur_mode;
  logic     mode_diff;

  assign first_s  = tick & ~half;
  assign second_s = tick & half;
  assign bit_out  = bit_q;
  assign valid    = valid_q;
  assign err      = err_q;

  lc_mode_track u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (first_s),
    .mode_in  (mode_in),
    .mode_cur (cur_mode),
    .mode_diff(mode_diff)
  );

  always_comb begin
    h1_d    = h1_q;
    ref_d   = ref_q;
    bit_d   = bit_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    if (first_s) begin
      h1_d = line;
      if (mode_diff) ref_d = 1'b1;
    end
    if (second_s) begin
      valid_d = 1'b1;
      ref_d   = line;
      case (cur_mode)
        LC_NRZI: bit_d = (line == ref_q);
        LC_FM0: begin
          bit_d = (h1_q == line);
          err_d = (h1_q == ref_q);
        end
        LC_FM1: begin
          bit_d = (h1_q != line);
          err_d = (h1_q == ref_q);
        end
        LC_MANCH: begin
          bit_d = h1_q;
          err_d = (h1_q == line);
        end
        default: bit_d = line;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_q    <= 1'b1;
      ref_q   <= 1'b1;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      h1_q    <= h1_d;
      ref_q   <= ref_d;
      bit_q   <= bit_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/line_codec.sv
module line_codec
  import line_codec_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LC_MODE_W-1:0] mode,
  input  logic                 tx_en,
  input  logic                 tx_tick,
  input  logic                 tx_data,
  output logic                 tx_req,
  output logic                 line_out,
  input  logic                 rx_tick,
  input  logic                 rx_half,
  input  logic                 rx_line,
  output logic                 rx_bit,
  output logic                 rx_valid,
  output logic                 rx_err
);

  localparam int SYNC_MSB = RST_STAGES - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_int;
  lc_mode_e          mode_sel;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
  end

  assign rst_int  = rst_sync_q[SYNC_MSB];
  assign mode_sel = lc_map_mode(mode);

  lc_encoder u_enc (
    .clk    (clk),
    .rst_n  (rst_int),
    .en     (tx_en),
    .tick   (tx_tick),
    .data   (tx_data),
    .mode_in(mode_sel),
    .line   (line_out),
    .req    (tx_req)
  );

  lc_decoder u_dec (
    .clk    (clk),
    .rst_n  (rst_int),
    .tick   (rx_tick),
    .half   (rx_half),
    .line   (rx_line),
    .mode_in(mode_sel),
    .bit_out(rx_bit),
    .valid  (rx_valid),
    .err    (rx_err)
  );

endmodule

// File: rtl/line_codec_chk.sv
module line_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_tick,
  input logic tx_req,
  input logic line_out,
  input logic rx_tick,
  input logic rx_half,
  input logic rx_valid,
  input logic rx_err
);

  // R2: a disabled transmitter parks the line at mark
  p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> line_out);

  // R2, R3: without a tick the enabled line holds its level
  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_tick) |=> $stable(line_out));

  // R12: data is only requested on an enabled tick
  p_req_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_tick && tx_en));

  // R8: a second-half sample yields a valid pulse next cycle
  p_valid_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && rx_half) |=> rx_valid);

  // R8: no valid pulse without a second-half sample
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_tick && rx_half) |=> !rx_valid);

  // R10: violations are reported only alongside a decoded bit
  p_err_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_valid);

endmodule

bind line_codec line_codec_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_int),
  .tx_en   (tx_en),
  .tx_tick (tx_tick),
  .tx_req  (tx_req),
  .line_out(line_out),
  .rx_tick (rx_tick),
  .rx_half (rx_half),
  .rx_valid(rx_valid),
  .rx_err  (rx_err)
);

// File: tb/line_codec_tb.sv
`timescale 1ns/1ps
module line_codec_tb;

  logic       clk;
  logic       rst_n;
  logic [2:0] mode;
  logic       tx_en, tx_tick, tx_data, tx_req, line_out;
  logic       rx_tick, rx_half, rx_line, rx_bit, rx_valid, rx_err;
  logic       use_force, force_val;

  int vectors = 0;
  int misses  = 0;

  // model state
  logic       ref_m;
  logic [2:0] prev_m;

  assign rx_line = use_force ? force_val : line_out;

  line_codec u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .tx_en(tx_en), .tx_tick(tx_tick), .tx_data(tx_data),
    .tx_req(tx_req), .line_out(line_out),
    .rx_tick(rx_tick), .rx_half(rx_half), .rx_line(rx_line),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .rx_err(rx_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  function automatic logic [2:0] eff(input logic [2:0] m);
    return (m <= 3'd4) ? m : 3'd0;
  endfunction

  // One cell in loopback; optional mode change between the halves.
  task automatic send_bit(input logic d, input logic [2:0] m, input bit mid,
                          input logic [2:0] m2, input string req);
    logic l1, l2;
    logic [2:0] e;
    e = eff(m);
    if (e != prev_m) ref_m = 1'b1;
    prev_m = e;
    case (e)
      3'd1:    begin l1 = d ? ref_m : ~ref_m; l2 = l1; end
      3'd2:    begin l1 = ~ref_m; l2 = d ? l1 : ~l1; end
      3'd3:    begin l1 = ~ref_m; l2 = d ? ~l1 : l1; end
      3'd4:    begin l1 = d; l2 = ~d; end
      default: begin l1 = d; l2 = d; end
    endcase
    ref_m = l2;
    @(negedge clk);
    mode = m; tx_data = d; tx_tick = 1'b1;
    #0.5 chk(tx_req, 1'b1, "R12", "req on boundary tick");
    @(negedge clk);
    tx_tick = 1'b0;
    chk(line_out, l1, req, "first half level");
    rx_tick = 1'b1; rx_half = 1'b0;
    @(negedge clk);
    rx_tick = 1'b0;
    if (mid) mode = m2;
    tx_tick = 1'b1; tx_data = ~d;
    #0.5 chk(tx_req, 1'b0, "R12", "no req at mid-cell");
    @(negedge clk);
    tx_tick = 1'b0;
    chk(line_out, l2, req, "second half level");
    rx_tick = 1'b1; rx_half = 1'b1;
    @(negedge clk);
    rx_tick = 1'b0;
    chk(rx_valid, 1'b1, "R8", "valid pulse");
    chk(rx_bit, d, "R8", "decoded bit");
    chk(rx_err, 1'b0, "R10", "no violation on legal cell");
    @(negedge clk);
    chk(rx_valid, 1'b0, "R8", "valid is one cycle");
  endtask

  // Receiver only, with forced line levels.
  task automatic rx_forced(input logic [2:0] m, input logic h1, input logic h2,
                           input logic exp_bit, input logic exp_err);
    @(negedge clk);
    mode = m; use_force = 1'b1; force_val = h1;
    rx_tick = 1'b1; rx_half = 1'b0;
    @(negedge clk);
    rx_tick = 1'b0;
    @(negedge clk);
    force_val = h2; rx_tick = 1'b1; rx_half = 1'b1;
    @(negedge clk);
    rx_tick = 1'b0;
    chk(rx_valid, 1'b1, "R10", "valid on forced cell");
    chk(rx_err, exp_err, "R10", "violation flag");
    chk(rx_bit, exp_bit, "R10", "forced cell bit");
    use_force = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_out, 1'b1, "R1", "line in reset");
    chk(rx_valid, 1'b0, "R1", "valid in reset");
    chk(rx_bit, 1'b0, "R1", "bit in reset");
    chk(rx_err, 1'b0, "R1", "err in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(line_out, 1'b1, "R1", "line after release");
    chk(rx_valid, 1'b0, "R1", "valid after release");
  endtask

  task automatic t_codes();
    logic [7:0] pat;
    pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) send_bit(pat[i], 3'd0, 1'b0, 3'd0, "R3");
    pat = 8'b0011_1000;
    for (int i = 0; i < 8; i++) send_bit(pat[i], 3'd1, 1'b0, 3'd1, "R4");
    pat = 8'b1100_1010;
    for (int i = 0; i < 8; i++) send_bit(pat[i], 3'd2, 1'b0, 3'd2, "R5");
    for (int i = 0; i < 8; i++) send_bit(pat[i], 3'd3, 1'b0, 3'd3, "R6");
    pat = 8'b0110_0011;
    for (int i = 0; i < 8; i++) send_bit(pat[i], 3'd4, 1'b0, 3'd4, "R7");
  endtask

  task automatic t_mode_switch();
    send_bit(1'b1, 3'd3, 1'b0, 3'd3, "R9");
    send_bit(1'b0, 3'd3, 1'b1, 3'd1, "R9");   // switch requested mid-cell
    send_bit(1'b1, 3'd1, 1'b0, 3'd1, "R9");   // NRZI from a high reference
    send_bit(1'b0, 3'd1, 1'b0, 3'd1, "R9");
    send_bit(1'b0, 3'd2, 1'b1, 3'd4, "R9");
    send_bit(1'b1, 3'd4, 1'b0, 3'd4, "R9");
  endtask

  task automatic t_unassigned();
    send_bit(1'b0, 3'd6, 1'b0, 3'd6, "R11");
    send_bit(1'b1, 3'd5, 1'b0, 3'd5, "R11");
    send_bit(1'b1, 3'd7, 1'b0, 3'd7, "R11");
    send_bit(1'b0, 3'd6, 1'b0, 3'd6, "R11");
  endtask

  task automatic t_violations();
    rx_forced(3'd4, 1'b1, 1'b1, 1'b1, 1'b1);
    rx_forced(3'd4, 1'b0, 1'b1, 1'b0, 1'b0);
    rx_forced(3'd2, 1'b1, 1'b1, 1'b1, 1'b1);  // no start toggle from high
    send_bit(1'b0, 3'd2, 1'b0, 3'd2, "R10");
    send_bit(1'b1, 3'd2, 1'b0, 3'd2, "R10");
  endtask

  task automatic t_disable();
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(line_out, 1'b1, "R2", "mark when disabled");
    tx_tick = 1'b1; tx_data = 1'b0;
    #0.5 chk(tx_req, 1'b0, "R2", "no req when disabled");
    @(negedge clk);
    tx_tick = 1'b0;
    chk(line_out, 1'b1, "R2", "mark after tick when disabled");
    tx_en = 1'b1;
    ref_m = 1'b1;
    send_bit(1'b0, 3'd0, 1'b0, 3'd0, "R2");
    send_bit(1'b1, 3'd0, 1'b0, 3'd0, "R2");
    send_bit(1'b0, 3'd1, 1'b0, 3'd1, "R2");
  endtask

  initial begin
    rst_n = 1'b0; mode = 3'd0; tx_en = 1'b1; tx_tick = 1'b0; tx_data = 1'b0;
    rx_tick = 1'b0; rx_half = 1'b0; use_force = 1'b0; force_val = 1'b1;
    ref_m = 1'b1; prev_m = 3'd0;
    t_reset();
    t_codes();
    t_mode_switch();
    t_unassigned();
    t_violations();
    t_disable();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule